// File: doc/BRIEF.md
# Atomic test-and-set semaphore unit

This block gives several requesting lanes atomic semaphore operations on a shared byte-wide memory. Each lane can issue three kinds of request. A test-and-set locks the shared bus, reads one byte and reports whether that byte was zero. It then writes the same byte back with its top bit forced high, and only after that write does it release the bus. A plain store writes a byte, normally to release a semaphore. A sync completes only after every store the lane has buffered has reached memory.

Each lane has its own engine and a one-entry write buffer. Stores complete into the buffer and drain to memory in the background whenever the lane can win the bus. A round-robin arbiter picks which lane drives the single memory port. While the owning lane asserts its lock, the arbiter keeps the bus with that lane, so no other lane's access can fall between the read and the write-back of a test-and-set. The memory port uses a valid/ready handshake. An access completes in the cycle in which valid and ready are both high.

Top module: `tas_sem_unit`

## Requirements
- R1: A test-and-set raises done_o for its lane with zero_o = 1 if the byte it read was 8'h00, and zero_o = 0 for any other value.
- R2: The write-back of a test-and-set goes to the address it read, and its data is the byte read OR 8'h80. Bit 7 is set and bits 6..0 are kept.
- R3: mem_lock_o is high during the read of a test-and-set. The next access on the memory port is that test-and-set's write-back. mem_lock_o is low in the cycle after the write-back is accepted.
- R4: done_o is a one-cycle pulse. busy_o is high from the cycle after a request is accepted until done. A request presented while busy_o is high is ignored, so a store issued then leaves memory unchanged and produces no done pulse of its own.
- R5: Request codes on op_i are 2'b00 for test-and-set, 2'b01 for store and 2'b10 or 2'b11 for sync. A store accepted while the lane's buffer is empty pulses done_o in the cycle after acceptance. The buffered byte is later written to memory.
- R6: A sync pulses done_o only after every store buffered by the lane has been written to memory.
- R7: A test-and-set issued while a store by the same lane is still buffered drains that store first, so the read returns the stored value.
- R8: When two lanes test-and-set the same byte, which is zero, exactly one of them sees zero_o = 1. At most one lane holds the bus at any time.
- R9: After reset, busy_o, done_o, mem_valid_o and mem_lock_o are all low.
- R10: While mem_valid_o is high and mem_ready_i is low, the address, the direction and the write data on the memory port stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NM | Request strobe per lane |
| op_i | input | NM x 2 | Request code per lane |
| addr_i | input | NM x AW | Byte address per lane |
| wdata_i | input | NM x 8 | Store data per lane |
| busy_o | output | NM | Lane is processing a request |
| done_o | output | NM | One-cycle completion pulse per lane |
| zero_o | output | NM | Byte read by the last test-and-set was zero |
| mem_valid_o | output | 1 | Memory access valid |
| mem_we_o | output | 1 | Memory access is a write |
| mem_lock_o | output | 1 | Owning lane holds the bus lock |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_ready_i | input | 1 | Memory accepts the access |
| mem_rdata_i | input | 8 | Memory read data |

## Verification
The assertions check on every cycle the properties of the bus itself. At most one lane holds a grant. The grant stays with the owner while its lock is held. A stalled access keeps its port values. Every locked write carries bit 7, the lock falls the cycle after the write-back, and done never lasts two cycles. Only the bench scenarios can show the data results. These are the value of the zero flag, a write-back equal to the read value with bit 7 set, exactly one winner when two lanes contend for the same byte at every offset and every initial value, a sync that waits for the buffered release store, a test-and-set that reads its own buffered store, and a request during busy that is dropped.

// File: rtl/tas_sem_pkg.sv
package tas_sem_pkg;
  typedef enum logic [1:0] {
    OP_TAS   = 2'b00,
    OP_STORE = 2'b01,
    OP_SYNC  = 2'b10
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FLUSH,
    S_ACQ,
    S_READ,
    S_WRITE,
    S_DONE
  } state_e;

  function automatic state_e first_state(input logic [1:0] op);
    return (op == OP_TAS) ? S_ACQ : S_DONE;
  endfunction
endpackage

// File: rtl/tas_sem_wbuf.sv
module tas_sem_wbuf #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_addr_i,
  input  logic [DW-1:0] load_data_i,
  input  logic          drain_i,
  output logic          full_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
    end else begin
      if (drain_i) full_o <= 1'b0;
      if (load_i) begin
        full_o <= 1'b1;
        addr_o <= load_addr_i;
        data_o <= load_data_i;
      end
    end
  end
endmodule

// File: rtl/tas_sem_engine.sv
module tas_sem_engine
  import tas_sem_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [1:0]    op_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          zero_o,
  output logic          breq_o,
  output logic          lock_o,
  output logic          bvalid_o,
  output logic          bwe_o,
  output logic [AW-1:0] baddr_o,
  output logic [DW-1:0] bwdata_o,
  input  logic          grant_i,
  input  logic          bready_i,
  input  logic [DW-1:0] brdata_i
);
  localparam logic [DW-1:0] SET_MASK = DW'(1) << (DW - 1);

  state_e        state_q, state_n;
  logic [1:0]    op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [DW-1:0] rd_q;
  logic          zero_q;

  logic          wb_full, wb_ld, drain_act, drain_done;
  logic [AW-1:0] wb_addr, ld_addr;
  logic [DW-1:0] wb_data, ld_data;

  assign drain_act  = wb_full && (state_q == S_IDLE || state_q == S_FLUSH);
  assign drain_done = drain_act && bready_i;

  tas_sem_wbuf #(.AW(AW), .DW(DW)) u_wbuf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (wb_ld),
    .load_addr_i (ld_addr),
    .load_data_i (ld_data),
    .drain_i     (drain_done),
    .full_o      (wb_full),
    .addr_o      (wb_addr),
    .data_o      (wb_data)
  );

  always_comb begin
    state_n = state_q;
    wb_ld   = 1'b0;
    ld_addr = addr_q;
    ld_data = data_q;
    unique case (state_q)
      S_IDLE: begin
        if (req_i) begin
          if (wb_full) begin
            state_n = S_FLUSH;
          end else begin
            state_n = first_state(op_i);
            if (op_i == OP_STORE) begin
              wb_ld   = 1'b1;
              ld_addr = addr_i;
              ld_data = wdata_i;
            end
          end
        end
      end
      S_FLUSH: begin
        if (!wb_full) begin
          state_n = first_state(op_q);
          wb_ld   = (op_q == OP_STORE);
        end
      end
      S_ACQ:   if (grant_i) state_n = S_READ;
      S_READ:  if (bready_i) state_n = S_WRITE;
      S_WRITE: if (bready_i) state_n = S_DONE;
      S_DONE:  state_n = S_IDLE;
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      op_q    <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      rd_q    <= '0;
      zero_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      if (state_q == S_IDLE && req_i) begin
        op_q   <= op_i;
        addr_q <= addr_i;
        data_q <= wdata_i;
      end
      if (state_q == S_READ && bready_i) begin
        rd_q   <= brdata_i;
        zero_q <= (brdata_i == '0);
      end
    end
  end

  // lock spans acquire through write-back; falls in DONE
  assign lock_o   = (state_q == S_ACQ) || (state_q == S_READ) || (state_q == S_WRITE);
  assign breq_o   = lock_o || drain_act;
  assign bvalid_o = (drain_act && grant_i) || (state_q == S_READ) || (state_q == S_WRITE);
  assign bwe_o    = drain_act || (state_q == S_WRITE);
  assign baddr_o  = drain_act ? wb_addr : addr_q;
  assign bwdata_o = drain_act ? wb_data : (rd_q | SET_MASK);
  assign busy_o   = (state_q != S_IDLE);
  assign done_o   = (state_q == S_DONE);
  assign zero_o   = zero_q;
endmodule

// File: rtl/tas_sem_arb.sv
module tas_sem_arb #(
  parameter int NM = 2,
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NM-1:0]          breq_i,
  input  logic [NM-1:0]          lock_i,
  input  logic [NM-1:0]          valid_i,
  input  logic [NM-1:0]          we_i,
  input  logic [NM-1:0][AW-1:0]  addr_i,
  input  logic [NM-1:0][DW-1:0]  wdata_i,
  output logic [NM-1:0]          grant_o,
  output logic [NM-1:0]          ready_o,
  output logic                   mem_valid_o,
  output logic                   mem_we_o,
  output logic                   mem_lock_o,
  output logic [AW-1:0]          mem_addr_o,
  output logic [DW-1:0]          mem_wdata_o,
  input  logic                   mem_ready_i
);
  localparam int IW = (NM > 1) ? $clog2(NM) : 1;

  logic          owned_q;
  logic [IW-1:0] owner_q, last_q, pick;
  logic          found, hold;

  always_comb begin
    int idx;
    pick  = '0;
    found = 1'b0;
    for (int k = 1; k <= NM; k++) begin
      idx = (int'(last_q) + k) % NM;
      if (!found && breq_i[idx]) begin
        pick  = IW'(idx);
        found = 1'b1;
      end
    end
  end

  assign hold = breq_i[owner_q] || lock_i[owner_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owned_q <= 1'b0;
      owner_q <= '0;
      last_q  <= IW'(NM - 1);
    end else if (owned_q && !hold) begin
      owned_q <= 1'b0;
    end else if (!owned_q && found) begin
      owned_q <= 1'b1;
      owner_q <= pick;
      last_q  <= pick;
    end
  end

  for (genvar g = 0; g < NM; g++) begin : g_lane
    assign grant_o[g] = owned_q && (owner_q == IW'(g));
    assign ready_o[g] = grant_o[g] && mem_ready_i;
  end

  assign mem_valid_o = owned_q && valid_i[owner_q];
  assign mem_we_o    = we_i[owner_q];
  assign mem_lock_o  = owned_q && lock_i[owner_q];
  assign mem_addr_o  = addr_i[owner_q];
  assign mem_wdata_o = wdata_i[owner_q];
endmodule

// File: rtl/tas_sem_unit.sv
module tas_sem_unit #(
  parameter int NM = 2,
  parameter int AW = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NM-1:0]         req_i,
  input  logic [NM-1:0][1:0]    op_i,
  input  logic [NM-1:0][AW-1:0] addr_i,
  input  logic [NM-1:0][7:0]    wdata_i,
  output logic [NM-1:0]         busy_o,
  output logic [NM-1:0]         done_o,
  output logic [NM-1:0]         zero_o,
  output logic                  mem_valid_o,
  output logic                  mem_we_o,
  output logic                  mem_lock_o,
  output logic [AW-1:0]         mem_addr_o,
  output logic [7:0]            mem_wdata_o,
  input  logic                  mem_ready_i,
  input  logic [7:0]            mem_rdata_i
);
  localparam int DW = 8;

  logic [NM-1:0]         breq, lock, bvalid, bwe, grant, bready;
  logic [NM-1:0][AW-1:0] baddr;
  logic [NM-1:0][DW-1:0] bwdata;

  for (genvar g = 0; g < NM; g++) begin : g_eng
    tas_sem_engine #(.AW(AW), .DW(DW)) u_eng (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .req_i    (req_i[g]),
      .op_i     (op_i[g]),
      .addr_i   (addr_i[g]),
      .wdata_i  (wdata_i[g]),
      .busy_o   (busy_o[g]),
      .done_o   (done_o[g]),
      .zero_o   (zero_o[g]),
      .breq_o   (breq[g]),
      .lock_o   (lock[g]),
      .bvalid_o (bvalid[g]),
      .bwe_o    (bwe[g]),
      .baddr_o  (baddr[g]),
      .bwdata_o (bwdata[g]),
      .grant_i  (grant[g]),
      .bready_i (bready[g]),
      .brdata_i (mem_rdata_i)
    );
  end

  tas_sem_arb #(.NM(NM), .AW(AW), .DW(DW)) u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .breq_i      (breq),
    .lock_i      (lock),
    .valid_i     (bvalid),
    .we_i        (bwe),
    .addr_i      (baddr),
    .wdata_i     (bwdata),
    .grant_o     (grant),
    .ready_o     (bready),
    .mem_valid_o (mem_valid_o),
    .mem_we_o    (mem_we_o),
    .mem_lock_o  (mem_lock_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ready_i (mem_ready_i)
  );
endmodule

// File: rtl/tas_sem_chk.sv
module tas_sem_chk #(
  parameter int NM = 2,
  parameter int AW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [NM-1:0] grant_i,
  input logic [NM-1:0] done_i,
  input logic          mem_valid_i,
  input logic          mem_we_i,
  input logic          mem_lock_i,
  input logic [AW-1:0] mem_addr_i,
  input logic [7:0]    mem_wdata_i,
  input logic          mem_ready_i
);
  p_one_grant_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_i));

  p_hold_stall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_i && !mem_ready_i |=> mem_valid_i && $stable(mem_addr_i)
      && $stable(mem_we_i) && $stable(mem_wdata_i));

  p_wb_bit7_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_i && mem_we_i && mem_lock_i |-> mem_wdata_i[7]);

  p_lock_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_i && mem_we_i && mem_lock_i && mem_ready_i |=> !mem_lock_i);

  p_lock_owner_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_lock_i |=> !mem_lock_i || $stable(grant_i));

  p_done_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i != '0) |=> ((done_i & $past(done_i)) == '0));
endmodule

bind tas_sem_unit tas_sem_chk #(.NM(NM), .AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .grant_i     (grant),
  .done_i      (done_o),
  .mem_valid_i (mem_valid_o),
  .mem_we_i    (mem_we_o),
  .mem_lock_i  (mem_lock_o),
  .mem_addr_i  (mem_addr_o),
  .mem_wdata_i (mem_wdata_o),
  .mem_ready_i (mem_ready_i)
);

// File: tb/tas_sem_unit_test.sv
module tas_sem_unit_test;
  localparam int NM = 2;
  localparam int AW = 4;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic [NM-1:0]         req = '0;
  logic [NM-1:0][1:0]    op = '0;
  logic [NM-1:0][AW-1:0] addr = '0;
  logic [NM-1:0][7:0]    wdata = '0;
  logic [NM-1:0]         busy, done, zero;
  logic                  mem_valid, mem_we, mem_lock, mem_ready;
  logic [AW-1:0]         mem_addr;
  logic [7:0]            mem_wdata, mem_rdata;

  logic [7:0]    mem [16];
  logic          ws_mode = 1'b0, ws_tog = 1'b0;
  logic          pre_en = 1'b0;
  logic [AW-1:0] pre_addr = '0;
  logic [7:0]    pre_val = '0;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;

  tas_sem_unit #(.NM(NM), .AW(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .addr_i(addr),
    .wdata_i(wdata), .busy_o(busy), .done_o(done), .zero_o(zero),
    .mem_valid_o(mem_valid), .mem_we_o(mem_we), .mem_lock_o(mem_lock),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata));

  assign mem_rdata = mem[mem_addr];
  assign mem_ready = mem_valid && (!ws_mode || ws_tog);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  // memory model and port monitor
  logic       rd_pend = 1'b0, drop_pend = 1'b0;
  logic [AW-1:0] ra = '0;
  logic [7:0] rv = '0;
  always @(posedge clk) begin
    ws_tog <= ~ws_tog;
    cyc++;
    if (cyc > 190000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      finish_run();
    end
    if (pre_en) mem[pre_addr] <= pre_val;
    if (rst_n) begin
      if (drop_pend) begin
        chk(!mem_lock, "R3 lock drop", int'(mem_lock), 0);
        drop_pend = 1'b0;
      end
      if (mem_valid && mem_ready) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (rd_pend) begin
          chk(mem_we && mem_addr == ra && mem_wdata == (rv | 8'h80),
              "R2 R3 write-back", int'(mem_wdata), int'(rv | 8'h80));
          rd_pend   = 1'b0;
          drop_pend = mem_lock;
        end else if (!mem_we) begin
          chk(mem_lock, "R3 locked read", int'(mem_lock), 1);
          ra      = mem_addr;
          rv      = mem_rdata;
          rd_pend = 1'b1;
        end
      end
    end
  end

  task automatic poke(input logic [AW-1:0] a, input logic [7:0] v);
    @(negedge clk); pre_en = 1'b1; pre_addr = a; pre_val = v;
    @(negedge clk); pre_en = 1'b0;
  endtask

  task automatic issue(input int l, input logic [1:0] o, input logic [AW-1:0] a,
                       input logic [7:0] d);
    @(negedge clk);
    req[l] = 1'b1; op[l] = o; addr[l] = a; wdata[l] = d;
    @(negedge clk);
    req[l] = 1'b0;
  endtask

  task automatic wait_done(input int l, output logic f);
    int n = 0;
    while (!done[l] && n < 200) begin @(negedge clk); n++; end
    chk(done[l], "R4 done seen", int'(done[l]), 1);
    f = zero[l];
  endtask

  initial begin
    logic f;
    repeat (3) @(negedge clk);
    chk(busy == '0 && done == '0 && !mem_valid && !mem_lock, "R9 reset",
        int'({busy, done, mem_valid, mem_lock}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == '0 && done == '0 && !mem_valid && !mem_lock, "R9 after reset",
        int'({busy, done, mem_valid, mem_lock}), 0);

    // R5: store completes next cycle, then lands in memory
    poke(4'd5, 8'h00);
    issue(0, 2'b01, 4'd5, 8'hA7);
    chk(done[0], "R5 store done timing", int'(done[0]), 1);
    @(negedge clk);
    chk(!done[0], "R4 pulse width", int'(done[0]), 0);
    repeat (6) @(negedge clk);
    chk(mem[5] == 8'hA7, "R5 store written", int'(mem[5]), 'hA7);

    // R7: test-and-set drains own buffered store first
    ws_mode = 1'b1;
    poke(4'd6, 8'h00);
    issue(0, 2'b01, 4'd6, 8'h3C);
    wait_done(0, f);
    issue(0, 2'b00, 4'd6, 8'h00);
    wait_done(0, f);
    chk(f == 1'b0, "R7 R1 flag after own store", int'(f), 0);
    repeat (2) @(negedge clk);
    chk(mem[6] == 8'hBC, "R7 R2 value", int'(mem[6]), 'hBC);

    // R4: request while busy is ignored
    ws_mode = 1'b0;
    poke(4'd7, 8'h01);
    poke(4'd8, 8'h11);
    issue(0, 2'b00, 4'd7, 8'h00);
    chk(busy[0], "R4 busy after accept", int'(busy[0]), 1);
    issue(0, 2'b01, 4'd8, 8'h55);
    begin
      int np = 0;
      repeat (30) begin if (done[0]) np++; @(negedge clk); end
      chk(np == 1, "R4 single done", np, 1);
    end
    chk(mem[8] == 8'h11, "R4 ignored store", int'(mem[8]), 'h11);
    chk(mem[7] == 8'h81, "R2 set bit7", int'(mem[7]), 'h81);
    chk(zero[0] == 1'b0, "R1 nonzero flag", int'(zero[0]), 0);

    // R8 R1 R6: contention sweep over initial value and start offset
    for (int v = 0; v < 256; v++) begin
      for (int d = 0; d < 3; d++) begin
        logic [1:0] seen, fl;
        int first;
        ws_mode = v[0];
        poke(4'd3, 8'(v));
        seen = '0; fl = '0; first = -1;
        for (int c = 0; c < 120 && seen != 2'b11; c++) begin
          @(negedge clk);
          req[0] = (c == 0); req[1] = (c == d);
          op = '0; addr[0] = 4'd3; addr[1] = 4'd3;
          for (int l = 0; l < NM; l++) begin
            if (done[l] && !seen[l]) begin
              seen[l] = 1'b1; fl[l] = zero[l];
              if (first < 0) first = l;
            end
          end
        end
        req = '0;
        chk(seen == 2'b11, "R8 both finish", int'(seen), 3);
        chk(int'(fl[0]) + int'(fl[1]) == int'(v == 0), "R8 one winner",
            int'(fl[0]) + int'(fl[1]), int'(v == 0));
        if (first >= 0)
          chk(fl[first] == (v == 0), "R1 first flag", int'(fl[first]), int'(v == 0));
        @(negedge clk);
        chk(mem[3] == (8'(v) | 8'h80), "R2 final byte", int'(mem[3]), v | 'h80);
        issue(d % 2, 2'b01, 4'd3, 8'h00);
        wait_done(d % 2, f);
        issue(d % 2, 2'b10 | 2'(v % 2), 4'd0, 8'h00);
        wait_done(d % 2, f);
        chk(mem[3] == 8'h00, "R6 sync drained release", int'(mem[3]), 0);
      end
    end
    finish_run();
  end
endmodule